// File: doc/BRIEF.md
# Early-Terminating Radix-16 Multiplier

This block is an iterative unsigned 32 x 32 multiplier that yields a full 64-bit product. Each step of the iteration consumes a 4-bit group of the multiplier operand and adds the multiplicand times that group into an accumulator. Two such groups are retired every clock, so one clock handles 8 multiplier bits.

A request starts with a one-cycle `start` pulse while the block is idle. The first busy cycle examines the captured operands. When either operand is below 2^15, that operand becomes the multiplier and the iteration stops after 16 bits. The multiply then takes 4 busy cycles instead of 6. If only the first operand is short, the two operands are exchanged internally. The last busy cycle raises `done` with the product valid.

Top module: `radix16_mult`

## Requirements
- R1: After reset, `busy` and `done` are 0 and `product` is 0.
- R2: A `start` high at a rising edge while idle captures `op_a` and `op_b` at that edge. `busy` is 1 from the next cycle on. Later changes on `op_a`/`op_b` do not affect the result.
- R3: In the cycle where `done` is 1, `product` equals the unsigned 64-bit product of the captured operands. It keeps that value until the end of the first busy cycle of the next accepted request.
- R4: When both operands are 2^15 or larger, `busy` is 1 for exactly 6 cycles and `done` is 1 in the 6th.
- R5: When either operand is below 2^15 (32767 counts as short, 32768 does not), `busy` is 1 for exactly 4 cycles and `done` is 1 in the 4th.
- R6: When only `op_a` is short, the operands are exchanged internally. The short latency of R5 applies and the product is still correct.
- R7: `done` is high for one cycle only, and `busy` is 0 in the cycle after it.
- R8: A `start` while `busy` is 1 is ignored. The running result and its timing are unchanged, and no new request follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Request strobe, accepted only while idle |
| op_a | input | 32 | First unsigned operand |
| op_b | input | 32 | Second unsigned operand |
| busy | output | 1 | A multiply is in progress |
| done | output | 1 | One-cycle pulse: product valid |
| product | output | 64 | Unsigned 64-bit result |

## Verification
Full-range random pairs exercise the 6-cycle path. Random pairs with one operand forced below 2^15 separate the two short cases: a short `op_b` needs no exchange and a short `op_a` does. Pairs straddling 32767/32768 show whether the size test is off by one bit. Zero and all-ones operands exercise the carries across all eight groups. A request with a second `start` inside its busy window, and with operands scrambled after capture, shows whether stray input activity can disturb a running multiply.

// File: rtl/radix16_mult.sv
module radix16_mult #(
  parameter int W          = 32,
  parameter int GROUP      = 4,
  parameter int STEPS      = 2,
  parameter int SHORT_BITS = 15
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           start,
  input  logic [W-1:0]   op_a,
  input  logic [W-1:0]   op_b,
  output logic           busy,
  output logic           done,
  output logic [2*W-1:0] product
);
  localparam int CHUNK     = GROUP * STEPS;
  localparam int PW        = 2 * W;
  localparam int FULL_IT   = W / CHUNK;
  localparam int SHORT_IT  = (SHORT_BITS + CHUNK - 1) / CHUNK;
  localparam int IW        = $clog2(FULL_IT + 1);
  localparam int LAT_FULL  = FULL_IT + 2;
  localparam int LAT_SHORT = SHORT_IT + 2;
  localparam int LW        = $clog2(LAT_FULL + 1) + 1;
  localparam logic [IW-1:0] FULL_N  = IW'(FULL_IT);
  localparam logic [IW-1:0] SHORT_N = IW'(SHORT_IT);

  typedef enum logic [1:0] {S_IDLE, S_LOAD, S_ITER, S_DONE} state_t;

  state_t        st;
  logic [W-1:0]  opa_q, opb_q, mcand, mplier;
  logic [PW-1:0] acc, partial, step_add;
  logic [IW-1:0] left, idx;
  logic [LW-1:0] lat_q;

  wire a_short = (opa_q >> SHORT_BITS) == '0;
  wire b_short = (opb_q >> SHORT_BITS) == '0;

  assign busy    = st != S_IDLE;
  assign done    = st == S_DONE;
  assign product = acc;

  always_comb begin
    partial = '0;
    for (int s = 0; s < STEPS; s++)
      partial = partial + ((PW'(mcand) * PW'(mplier[s*GROUP +: GROUP])) << (s * GROUP));
    step_add = partial << (CHUNK * int'(idx));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= S_IDLE;
      opa_q  <= '0;
      opb_q  <= '0;
      mcand  <= '0;
      mplier <= '0;
      acc    <= '0;
      left   <= '0;
      idx    <= '0;
    end else begin
      case (st)
        S_IDLE: if (start) begin
          opa_q <= op_a;
          opb_q <= op_b;
          st    <= S_LOAD;
        end
        S_LOAD: begin
          acc <= '0;
          idx <= '0;
          if (a_short && !b_short) begin
            mcand  <= opb_q;
            mplier <= opa_q;
          end else begin
            mcand  <= opa_q;
            mplier <= opb_q;
          end
          left <= (a_short || b_short) ? SHORT_N : FULL_N;
          st   <= S_ITER;
        end
        S_ITER: begin
          acc    <= acc + step_add;
          mplier <= mplier >> CHUNK;
          idx    <= idx + 1'b1;
          left   <= left - 1'b1;
          if (left == IW'(1)) st <= S_DONE;
        end
        S_DONE:  st <= S_IDLE;
        default: st <= S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                     lat_q <= '0;
    else if (st == S_IDLE && start) lat_q <= LW'(1);
    else if (busy)                  lat_q <= lat_q + 1'b1;
  end

  assert_start_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(start));

  assert_product_R3: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> product == PW'(opa_q) * PW'(opb_q));

  assert_latency_R4_R5: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> lat_q == ((a_short || b_short) ? LW'(LAT_SHORT) : LW'(LAT_FULL)));

  assert_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done && !busy);

  assert_ignore_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start) |=> $stable(opa_q) && $stable(opb_q));
endmodule

// File: tb/radix16_mult_tb.sv
module radix16_mult_tb_top;
  logic        clk = 0, rst_n = 0, start = 0;
  logic [31:0] op_a = 0, op_b = 0;
  logic        busy, done;
  logic [63:0] product;
  int errors = 0, checks = 0, cycles = 0;
  bit finished = 0;

  radix16_mult dut_i (.clk(clk), .rst_n(rst_n), .start(start), .op_a(op_a),
                      .op_b(op_b), .busy(busy), .done(done), .product(product));

  always #10 clk = ~clk;

  function automatic logic [63:0] exp_prod(logic [31:0] a, logic [31:0] b);
    return {32'd0, a} * {32'd0, b};
  endfunction

  function automatic int exp_lat(logic [31:0] a, logic [31:0] b);
    return (a < 32'd32768 || b < 32'd32768) ? 4 : 6;
  endfunction

  task automatic chk(bit ok, string req, string what, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=%0d expected<=150000", cycles);
      summary();
    end
  end

  task automatic run(logic [31:0] a, logic [31:0] b, bit poke);
    int n;
    logic [63:0] ep = exp_prod(a, b);
    int el = exp_lat(a, b);
    string lreq = (el == 4) ? ((a < 32'd32768 && b >= 32'd32768) ? "R6" : "R5") : "R4";
    @(negedge clk); op_a = a; op_b = b; start = 1;
    @(negedge clk); start = 0; op_a = $urandom; op_b = $urandom;
    n = 1;
    chk(busy === 1'b1, "R2", "busy after start", 64'(busy), 64'd1);
    while (!done && n < 20) begin
      @(negedge clk); n++;
      start = poke && n == 2;
      if (start) begin op_a = ~a; op_b = ~b; end
    end
    start = 0;
    chk(n == el, lreq, "cycles to done", 64'(n), 64'(el));
    chk(product === ep, poke ? "R8" : "R3", "product at done", product, ep);
    @(negedge clk);
    chk(!done && !busy, "R7", "done/busy after pulse", {62'd0, done, busy}, 64'd0);
    chk(product === ep, "R3", "product held", product, ep);
    if (poke) begin
      @(negedge clk);
      chk(!busy, "R8", "no restart from ignored start", 64'(busy), 64'd0);
    end
  endtask

  initial begin
    void'($urandom(32'd20240611));
    #35;
    chk(!busy && !done && product == 0, "R1", "reset outputs",
        {busy, done, product[61:0]}, 64'd0);
    rst_n = 1;
    run(32'd0, 32'd0, 0);
    run(32'hFFFF_FFFF, 32'hFFFF_FFFF, 0);
    run(32'd32767, 32'hDEAD_BEEF, 0);
    run(32'd32768, 32'hDEAD_BEEF, 0);
    run(32'hCAFE_F00D, 32'd32767, 0);
    run(32'hCAFE_F00D, 32'd32768, 0);
    run(32'd12345, 32'd321, 0);
    run(32'h8000_0001, 32'h0001_0000, 0);
    run(32'h1234_5678, 32'h9ABC_DEF0, 1);
    run(32'd7, 32'hFFFF_FFFF, 1);
    for (int i = 0; i < 60; i++) run($urandom, $urandom, 0);
    for (int i = 0; i < 30; i++) run($urandom & 32'h7FFF, $urandom, 0);
    for (int i = 0; i < 30; i++) run($urandom, $urandom & 32'h7FFF, i % 5 == 0);
    summary();
  end
endmodule